// File: doc/BRIEF.md
# Byte-Bus Load/Store Unit

This unit carries out the memory operations of a small 16-bit processor that sits on an 8-bit external bus. The core hands it a base register value, a 7-bit signed offset, an operation code and, for stores, the 16-bit source value. The unit adds the offset to the base, runs one or two byte cycles on the bus, and returns the loaded value already widened to 16 bits. A one-cycle `done` pulse tells the core that the result is ready or that the store has finished.

Byte operations make a single bus cycle. Word operations make two bus cycles, low byte first. A byte access therefore takes three cycles from the request to `done`, and a word access takes four. A new request can be taken in the cycle where `done` is high, so accesses can follow each other with no idle cycle between them. Reading registers, decoding instructions and trapping on alignment belong to the core and are not part of this unit.

Top module: `bytebus_lsu`

## Requirements
- R1: The bus address of the first byte cycle equals `req_base` plus `req_offset` sign-extended from 7 bits, modulo 2^16.
- R2: A byte operation makes exactly one bus cycle. The request is taken at clock edge k, the bus cycle runs between edges k and k+1, and `done` is high between edges k+1 and k+2.
- R3: A word operation moves the low byte at the effective address and then the high byte at the effective address plus one, wrapping from 0xFFFF to 0x0000. `done` is high between edges k+2 and k+3.
- R4: A signed byte load (op 0) puts the byte in bits 7:0 of `ld_data` and copies its bit 7 into bits 15:8. An unsigned byte load (op 1) clears bits 15:8.
- R5: A word load (op 2) returns `{high byte, low byte}` on `ld_data`.
- R6: During each bus cycle of a store, `bus_rnw` is 0 and `bus_wdata` carries the byte being written: bits 7:0 of `req_wdata` in the first cycle and bits 15:8 in the second (word store, op 5). A byte store (op 4) writes bits 7:0. At all other times `bus_rnw` is 1. A store leaves `ld_data` unchanged.
- R7: `done` is high for exactly one cycle per operation.
- R8: A request is taken only when the unit is idle or in its `done` cycle. A request made during a bus cycle has no effect.
- R9: Op codes 0 (LB), 1 (LBU), 2 (LW), 4 (SB) and 5 (SW) are valid. A request with op 3, 6 or 7 is ignored: no bus cycle and no `done`.
- R10: After reset `done` is 0, `bus_rnw` is 1, and `bus_addr`, `bus_wdata` and `ld_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R9) |
| req_base | input | 16 | Base register value |
| req_offset | input | 7 | Signed offset |
| req_wdata | input | 16 | Store source value |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rnw | output | 1 | High for read, low for write |
| bus_rdata | input | 8 | Bus read data, sampled at the end of each read cycle |
| ld_data | output | 16 | Extended load result |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the sequencer is in the wrong state, the fault shows on the bus at the very next edge. It appears as a second address cycle after a byte operation, a missing high-byte cycle, a write strobe during a load, or `done` one cycle too early or too late. The bench samples the bus in every cycle of every transfer, so it catches these faults in the cycle where they happen. A wrongly captured low byte or a wrong extension shows only on `ld_data` in the `done` cycle, and the bench compares it with a value computed from a known memory pattern.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [2:0] OP_LB  = 3'd0;
  localparam logic [2:0] OP_LBU = 3'd1;
  localparam logic [2:0] OP_LW  = 3'd2;
  localparam logic [2:0] OP_SB  = 3'd4;
  localparam logic [2:0] OP_SW  = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } lsu_state_e;

  function automatic logic op_is_store(input logic [2:0] op);
    return op[2];
  endfunction

  function automatic logic op_is_word(input logic [2:0] op);
    return (op == OP_LW) || (op == OP_SW);
  endfunction

  function automatic logic op_is_legal(input logic [2:0] op);
    return (op == OP_LB) || (op == OP_LBU) || (op == OP_LW) ||
           (op == OP_SB) || (op == OP_SW);
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 7
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
    eff_addr = base + off_ext;
  end
endmodule

// File: rtl/lsu_extend.sv
module lsu_extend #(
  parameter int BYTE_W = 8
) (
  input  logic [2:0]          op,
  input  logic [BYTE_W-1:0]   lo_byte,
  input  logic [BYTE_W-1:0]   hi_byte,
  output logic [2*BYTE_W-1:0] word
);
  import lsu_pkg::*;

  always_comb begin
    unique case (op)
      OP_LB:   word = {{BYTE_W{lo_byte[BYTE_W-1]}}, lo_byte};
      OP_LW:   word = {hi_byte, lo_byte};
      default: word = {{BYTE_W{1'b0}}, lo_byte};
    endcase
  end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [2:0]          req_op,
  input  logic [ADDR_W-1:0]   eff_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  input  logic [BYTE_W-1:0]   bus_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [BYTE_W-1:0]   bus_wdata,
  output logic                bus_rnw,
  output logic                done,
  output logic [2:0]          op_q,
  output logic [BYTE_W-1:0]   lo_q,
  output logic                hi_phase,
  output logic                ld_we
);
  import lsu_pkg::*;

  lsu_state_e        st;
  logic [BYTE_W-1:0] wd_hi_q;
  logic              accept;

  always_comb begin
    accept   = req_valid && op_is_legal(req_op) &&
               ((st == ST_IDLE) || (st == ST_FIN));
    hi_phase = (st == ST_HI);
    ld_we    = !op_is_store(op_q) &&
               (((st == ST_LO) && !op_is_word(op_q)) || (st == ST_HI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_rnw   <= 1'b1;
      done      <= 1'b0;
      op_q      <= OP_LB;
      lo_q      <= '0;
      wd_hi_q   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_LO: begin
          lo_q <= bus_rdata;
          if (op_is_word(op_q)) begin
            st        <= ST_HI;
            bus_addr  <= bus_addr + 1'b1;
            bus_wdata <= op_is_store(op_q) ? wd_hi_q : '0;
          end else begin
            st        <= ST_FIN;
            done      <= 1'b1;
            bus_rnw   <= 1'b1;
            bus_wdata <= '0;
          end
        end
        ST_HI: begin
          st        <= ST_FIN;
          done      <= 1'b1;
          bus_rnw   <= 1'b1;
          bus_wdata <= '0;
        end
        default: begin
          if (accept) begin
            st        <= ST_LO;
            op_q      <= req_op;
            wd_hi_q   <= req_wdata[2*BYTE_W-1:BYTE_W];
            bus_addr  <= eff_addr;
            bus_rnw   <= !op_is_store(req_op);
            bus_wdata <= op_is_store(req_op) ? req_wdata[BYTE_W-1:0] : '0;
          end else begin
            st        <= ST_IDLE;
            bus_rnw   <= 1'b1;
            bus_wdata <= '0;
          end
        end
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  hi_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HI) |-> (bus_addr == ADDR_W'($past(bus_addr) + 1'b1)));

  // R2
  byte_single_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HI) |-> op_is_word(op_q));

  // R6
  write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rnw |-> (((st == ST_LO) || (st == ST_HI)) && op_is_store(op_q)));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_LO) || (st == ST_HI)) |=> $stable(op_q));
endmodule

// File: rtl/bytebus_lsu.sv
module bytebus_lsu #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [2:0]          req_op,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [BYTE_W-1:0]   bus_wdata,
  output logic                bus_rnw,
  input  logic [BYTE_W-1:0]   bus_rdata,
  output logic [2*BYTE_W-1:0] ld_data,
  output logic                done
);
  import lsu_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] eff_addr;
  logic [2:0]        op_q;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] lo_src;
  logic              hi_phase;
  logic              ld_we;
  logic [WORD_W-1:0] ext_word;

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .base     (req_base),
    .offset   (req_offset),
    .eff_addr (eff_addr)
  );

  lsu_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .eff_addr  (eff_addr),
    .req_wdata (req_wdata),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rnw   (bus_rnw),
    .done      (done),
    .op_q      (op_q),
    .lo_q      (lo_q),
    .hi_phase  (hi_phase),
    .ld_we     (ld_we)
  );

  assign lo_src = hi_phase ? lo_q : bus_rdata;

  lsu_extend #(.BYTE_W(BYTE_W)) u_ext (
    .op      (op_q),
    .lo_byte (lo_src),
    .hi_byte (bus_rdata),
    .word    (ext_word)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ld_data <= '0;
    else if (ld_we)
      ld_data <= ext_word;
  end

  // R4
  lb_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (op_q == OP_LB)) |-> (ld_data[WORD_W-1:BYTE_W] == {BYTE_W{ld_data[BYTE_W-1]}}));

  // R4
  lbu_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (op_q == OP_LBU)) |-> (ld_data[WORD_W-1:BYTE_W] == '0));
endmodule

// File: tb/bytebus_lsu_bench.sv
module bytebus_lsu_bench;
  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] base;
    logic [6:0]  off;
    logic [15:0] wd;
    logic [15:0] ea;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 16'h1000, 7'h05, 16'h0000, 16'h1005},
    '{3'd0, 16'h00D2, 7'h7E, 16'h0000, 16'h00D0},
    '{3'd1, 16'h00D2, 7'h7E, 16'h0000, 16'h00D0},
    '{3'd2, 16'h1234, 7'h3F, 16'h0000, 16'h1273},
    '{3'd2, 16'hFFFF, 7'h00, 16'h0000, 16'hFFFF},
    '{3'd4, 16'h0300, 7'h40, 16'hBEEF, 16'h02C0},
    '{3'd5, 16'h4000, 7'h10, 16'hCAFE, 16'h4010},
    '{3'd1, 16'h7FC0, 7'h3F, 16'h0000, 16'h7FFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] req_base = '0;
  logic [6:0]  req_offset = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rnw;
  logic [7:0]  bus_rdata;
  logic [15:0] ld_data;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_rdata = memf(bus_addr);

  bytebus_lsu u_bytebus_lsu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rnw(bus_rnw),
    .bus_rdata(bus_rdata), .ld_data(ld_data), .done(done)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One transaction; b2b skips the leading idle edge, junk issues a request while busy.
  task automatic run(input vec_t v, input bit b2b, input bit junk);
    logic        word = (v.op == 3'd2) || (v.op == 3'd5);
    logic        store = v.op[2];
    logic [15:0] ld_before;
    logic [15:0] exp_ld;
    logic [7:0]  lo;
    logic [7:0]  hi;
    if (!b2b) @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_base = v.base;
    req_offset = v.off; req_wdata = v.wd;
    ld_before = ld_data;
    @(negedge clk);
    if (junk) begin req_op = 3'd4; req_base = 16'h0BAD; req_wdata = 16'h1111; end
    else req_valid = 1'b0;
    chk(bus_addr == v.ea, "R1", bus_addr, v.ea);
    chk(bus_rnw == !store, "R6", {15'd0, bus_rnw}, {15'd0, !store});
    if (store) chk(bus_wdata == v.wd[7:0], "R6", {8'd0, bus_wdata}, {8'd0, v.wd[7:0]});
    chk(done == 1'b0, "R2", {15'd0, done}, 16'd0);
    lo = memf(v.ea);
    hi = memf(v.ea + 16'd1);
    if (word) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_addr == v.ea + 16'd1, "R3", bus_addr, v.ea + 16'd1);
      chk(bus_rnw == !store, "R6", {15'd0, bus_rnw}, {15'd0, !store});
      if (store) chk(bus_wdata == v.wd[15:8], "R6", {8'd0, bus_wdata}, {8'd0, v.wd[15:8]});
      chk(done == 1'b0, "R3", {15'd0, done}, 16'd0);
    end
    @(negedge clk);
    chk(done == 1'b1, word ? "R3" : "R2", {15'd0, done}, 16'd1);
    chk(bus_rnw == 1'b1, "R6", {15'd0, bus_rnw}, 16'd1);
    case (v.op)
      3'd0:    exp_ld = {{8{lo[7]}}, lo};
      3'd1:    exp_ld = {8'd0, lo};
      3'd2:    exp_ld = {hi, lo};
      default: exp_ld = ld_before;
    endcase
    chk(ld_data == exp_ld, store ? "R6" : (word ? "R5" : "R4"), ld_data, exp_ld);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(done == 1'b0, "R10", {15'd0, done}, 16'd0);
    chk(bus_rnw == 1'b1, "R10", {15'd0, bus_rnw}, 16'd1);
    chk(bus_addr == 16'd0, "R10", bus_addr, 16'd0);
    chk(bus_wdata == 8'd0, "R10", {8'd0, bus_wdata}, 16'd0);
    chk(ld_data == 16'd0, "R10", ld_data, 16'd0);

    for (int i = 0; i < NVEC; i++) run(VECS[i], 1'b0, 1'b0);

    // R8: request during a word load's bus cycles has no effect
    run(VECS[3], 1'b0, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0 && bus_rnw == 1'b1, "R8", {14'd0, done, bus_rnw}, 16'd1);
    end

    // R8: request in the done cycle is taken, no idle cycle between
    run(VECS[6], 1'b0, 1'b0);
    run(VECS[0], 1'b1, 1'b0);
    run(VECS[4], 1'b1, 1'b0);

    // R9: illegal op codes start nothing
    for (int k = 0; k < 3; k++) begin
      logic [15:0] a_before;
      @(negedge clk);
      a_before = bus_addr;
      req_valid = 1'b1; req_op = (k == 0) ? 3'd3 : ((k == 1) ? 3'd6 : 3'd7);
      req_base = 16'h5555; req_offset = 7'h01; req_wdata = 16'h7777;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) begin
        chk(done == 1'b0 && bus_rnw == 1'b1, "R9", {14'd0, done, bus_rnw}, 16'd1);
        chk(bus_addr == a_before, "R9", bus_addr, a_before);
        @(negedge clk);
      end
    end

    // R7: done low again the cycle after a pulse
    run(VECS[5], 1'b0, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R7", {15'd0, done}, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule